// File: doc/BRIEF.md
# TLB Victim Selector

This block decides which slot of a small fully-associative translation cache is overwritten when a new translation has to be stored. The surrounding cache reports which slots currently hold a translation, pulses an allocate request when a miss needs a slot, and pulses a touch with a slot index whenever an existing translation is used. The selector answers every accepted allocation with a slot index one clock later.

Two replacement policies can be chosen at run time. One is a plain rotating pointer. The other is least-recently-used, tracked with a small age counter per slot. In LRU mode, a second select decides how a tie among equally old slots is broken: take the lowest such index, or take the first one found when scanning upward (with wrap) from the rotating pointer. Empty slots are always filled first. A cache-off input stops the cache from being used: allocations and touches are then ignored and no state moves.

The entry count must be a power of two. The age counter width equals the index width.

Top module: `tlb_victim_sel`

## Requirements
- R1: After reset `victim_valid_o` is 0, every slot age is 0 and the rotating pointer is 0, so the first all-valid allocation picks slot 0 in either mode.
- R2: When an allocation is accepted and any `valid_i` bit is 0, the victim is the lowest-indexed slot whose valid bit is 0, in either mode.
- R3: With `repl_mode_i` = 0 (round-robin) and all slots valid, the victim is the rotating pointer. The pointer advances by one modulo the entry count on every accepted allocation, in both modes.
- R4: With `repl_mode_i` = 1 (LRU), all slots valid and `tie_sel_i` = 0, the victim is the lowest-indexed slot among those holding the largest age.
- R5: With `repl_mode_i` = 1, all slots valid and `tie_sel_i` = 1, the victim is the first slot holding the largest age, scanning upward from the rotating pointer and wrapping past the top entry to slot 0.
- R6: On an accepted touch or allocation of slot k whose age was a, slot k's age becomes 0. Every other slot whose age was a or less gains one, saturating at the maximum. Other slots keep their age.
- R7: A touch in the same cycle as an accepted allocation is ignored; only the allocated slot is aged as the newest.
- R8: While `cache_off_i` = 1, allocations and touches are ignored. No victim is produced, and the ages and the pointer do not change.
- R9: `victim_valid_o` is high for exactly the one cycle after each accepted allocation. At that point `victim_idx_o` holds the chosen slot, and it keeps that value until the next allocation.
- R10: The mode and tie-break inputs are used only in the cycle of the allocate request. Changing them leaves the ages and the pointer untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_off_i | input | 1 | 1 = cache unused; requests ignored |
| valid_i | input | N_ENTRIES | Per-slot occupied flags |
| alloc_req_i | input | 1 | Request a slot for a new translation |
| touch_req_i | input | 1 | A slot was used by a lookup hit |
| touch_idx_i | input | log2(N_ENTRIES) | Slot that was used |
| repl_mode_i | input | 1 | 0 round-robin, 1 least-recently-used |
| tie_sel_i | input | 1 | LRU tie-break: 0 from slot 0, 1 from pointer |
| victim_valid_o | output | 1 | One-cycle pulse after an accepted allocation |
| victim_idx_o | output | log2(N_ENTRIES) | Chosen slot |

## Verification
The selection rule is driven with partly empty valid masks in both modes, which separates "fill empty first" from the policy. All-valid requests are sent in round-robin mode, and in LRU mode with each tie-break, from age states shaped by earlier allocations and touches. Because one state has old slots on both sides of the pointer, the two tie-breaks give different answers, and another state holds its only old slots below the pointer, which forces the scan to wrap. Simultaneous allocate and touch, requests while the cache is off, and resets taken from a non-uniform age state are each followed by an LRU request whose answer exposes whether a touch, a request or stale age was wrongly kept.

// File: rtl/tlb_victim_sel_pkg.sv
package tlb_victim_sel_pkg;

  typedef enum logic {
    REPL_ROUND = 1'b0,
    REPL_LRU   = 1'b1
  } repl_e;

  typedef enum logic {
    SCAN_FROM_ZERO = 1'b0,
    SCAN_FROM_PTR  = 1'b1
  } scan_e;

endpackage

// File: rtl/tlb_vs_rr_ptr.sv
// Rotating pointer, advanced once per accepted allocation.
module tlb_vs_rr_ptr #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i) begin
      ptr_d = ptr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv_i) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/tlb_vs_age_array.sv
// Per-slot age counters; the updated slot becomes newest and every slot
// that was as young or younger moves one step older (saturating).
module tlb_vs_age_array #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int AGE_W = IDX_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           upd_i,
  input  logic [IDX_W-1:0]               upd_idx_i,
  output logic [N_ENTRIES-1:0][AGE_W-1:0] ages_o
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [N_ENTRIES-1:0][AGE_W-1:0] age_q;
  logic [N_ENTRIES-1:0][AGE_W-1:0] age_d;
  logic [AGE_W-1:0]                ref_age;

  assign ref_age = age_q[upd_idx_i];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    logic hit;
    logic bump;

    assign hit  = (upd_idx_i == IDX_W'(g));
    assign bump = (age_q[g] <= ref_age) && (age_q[g] != AGE_MAX);

    always_comb begin
      age_d[g] = age_q[g];
      if (hit) begin
        age_d[g] = '0;
      end else if (bump) begin
        age_d[g] = age_q[g] + AGE_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[g] <= '0;
      end else if (upd_i) begin
        age_q[g] <= age_d[g];
      end
    end
  end

  assign ages_o = age_q;

endmodule

// File: rtl/tlb_vs_pick.sv
// Combinational victim choice: empty slot first, then the selected policy.
module tlb_vs_pick
  import tlb_victim_sel_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int AGE_W = IDX_W
) (
  input  logic [N_ENTRIES-1:0]            valid_i,
  input  logic [N_ENTRIES-1:0][AGE_W-1:0] ages_i,
  input  logic [IDX_W-1:0]                rr_i,
  input  logic                            mode_i,
  input  logic                            tie_i,
  output logic [IDX_W-1:0]                pick_o
);

  repl_e            mode;
  scan_e            scan;
  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [AGE_W-1:0] max_age;
  logic [IDX_W-1:0] low_old;
  logic [IDX_W-1:0] rot_old;
  logic             rot_hit;
  logic [IDX_W-1:0] cand;

  assign mode = repl_e'(mode_i);
  assign scan = scan_e'(tie_i);

  // Lowest empty slot.
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // Largest age and its lowest holder.
  always_comb begin
    max_age = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (ages_i[i] > max_age) begin
        max_age = ages_i[i];
      end
    end
    low_old = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (ages_i[i] == max_age) begin
        low_old = IDX_W'(i);
      end
    end
  end

  // First oldest slot at or after the pointer, wrapping.
  always_comb begin
    rot_hit = 1'b0;
    rot_old = rr_i;
    cand    = rr_i;
    for (int k = 0; k < N_ENTRIES; k++) begin
      cand = rr_i + IDX_W'(k);
      if (!rot_hit && (ages_i[cand] == max_age)) begin
        rot_hit = 1'b1;
        rot_old = cand;
      end
    end
  end

  always_comb begin
    if (any_free) begin
      pick_o = free_idx;
    end else if (mode == REPL_ROUND) begin
      pick_o = rr_i;
    end else if (scan == SCAN_FROM_PTR) begin
      pick_o = rot_old;
    end else begin
      pick_o = low_old;
    end
  end

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int AGE_W = IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cache_off_i,
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic                 alloc_req_i,
  input  logic                 touch_req_i,
  input  logic [IDX_W-1:0]     touch_idx_i,
  input  logic                 repl_mode_i,
  input  logic                 tie_sel_i,
  output logic                 victim_valid_o,
  output logic [IDX_W-1:0]     victim_idx_o
);

  logic                            alloc_go;
  logic                            touch_go;
  logic                            upd;
  logic [IDX_W-1:0]                upd_idx;
  logic [IDX_W-1:0]                rr_ptr;
  logic [IDX_W-1:0]                pick;
  logic [N_ENTRIES-1:0][AGE_W-1:0] ages;

  logic                            vv_q;
  logic                            vv_d;
  logic [IDX_W-1:0]                idx_q;
  logic [IDX_W-1:0]                idx_d;

  // Request qualification: cache-off blocks both, allocation wins a collision.
  assign alloc_go = alloc_req_i & ~cache_off_i;
  assign touch_go = touch_req_i & ~alloc_req_i & ~cache_off_i;
  assign upd      = alloc_go | touch_go;
  assign upd_idx  = alloc_go ? pick : touch_idx_i;

  tlb_vs_rr_ptr #(.N_ENTRIES(N_ENTRIES)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (alloc_go),
    .ptr_o (rr_ptr)
  );

  tlb_vs_age_array #(.N_ENTRIES(N_ENTRIES)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (upd),
    .upd_idx_i (upd_idx),
    .ages_o    (ages)
  );

  tlb_vs_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
    .valid_i (valid_i),
    .ages_i  (ages),
    .rr_i    (rr_ptr),
    .mode_i  (repl_mode_i),
    .tie_i   (tie_sel_i),
    .pick_o  (pick)
  );

  always_comb begin
    vv_d  = alloc_go;
    idx_d = idx_q;
    if (alloc_go) begin
      idx_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q <= 1'b0;
    end else begin
      vv_q <= vv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (alloc_go) begin
      idx_q <= idx_d;
    end
  end

  assign victim_valid_o = vv_q;
  assign victim_idx_o   = idx_q;

endmodule

// File: rtl/tlb_victim_sel_chk.sv
module tlb_victim_sel_chk #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int AGE_W = IDX_W
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cache_off_i,
  input logic [N_ENTRIES-1:0]            valid_i,
  input logic                            alloc_req_i,
  input logic                            touch_req_i,
  input logic [IDX_W-1:0]                touch_idx_i,
  input logic                            repl_mode_i,
  input logic                            victim_valid_o,
  input logic [IDX_W-1:0]                victim_idx_o,
  input logic [IDX_W-1:0]                rr_ptr,
  input logic [N_ENTRIES-1:0][AGE_W-1:0] ages
);

  logic [N_ENTRIES-1:0] below_mask;
  assign below_mask = (N_ENTRIES'(1) << victim_idx_o) - N_ENTRIES'(1);

  // R9: a victim appears only after an accepted allocation
  p_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid_o |-> $past(alloc_req_i && !cache_off_i));

  // R9: every accepted allocation produces a victim
  p_pulse_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req_i && !cache_off_i) |=> victim_valid_o);

  // R8: cache-off freezes state and blocks output
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cache_off_i |=> (!victim_valid_o && $stable(ages) && $stable(rr_ptr)));

  // R2: victim is an empty slot with no empty slot below it
  p_free_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req_i && !cache_off_i && (valid_i != '1)) |=>
      (($past(valid_i) & (N_ENTRIES'(1) << victim_idx_o)) == '0) &&
      (($past(valid_i) & below_mask) == below_mask));

  // R3: round-robin victim is the pointer
  p_rr_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req_i && !cache_off_i && (valid_i == '1) && !repl_mode_i) |=>
      (victim_idx_o == $past(rr_ptr)));

  // R3: pointer steps once per accepted allocation
  p_rr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req_i && !cache_off_i) |=> (rr_ptr == $past(rr_ptr) + IDX_W'(1)));

  // R6: touched slot becomes newest
  p_touch_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_req_i && !alloc_req_i && !cache_off_i) |=> (ages[$past(touch_idx_i)] == '0));

  // R6: allocated slot becomes newest
  p_alloc_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid_o |-> (ages[victim_idx_o] == '0));

endmodule

bind tlb_victim_sel tlb_victim_sel_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cache_off_i    (cache_off_i),
  .valid_i        (valid_i),
  .alloc_req_i    (alloc_req_i),
  .touch_req_i    (touch_req_i),
  .touch_idx_i    (touch_idx_i),
  .repl_mode_i    (repl_mode_i),
  .victim_valid_o (victim_valid_o),
  .victim_idx_o   (victim_idx_o),
  .rr_ptr         (rr_ptr),
  .ages           (ages)
);

// File: tb/tlb_victim_sel_tb.sv
module tlb_victim_sel_tb;

  logic       clk;
  logic       rst_n;
  logic       cache_off_i;
  logic [7:0] valid_i;
  logic       alloc_req_i;
  logic       touch_req_i;
  logic [2:0] touch_idx_i;
  logic       repl_mode_i;
  logic       tie_sel_i;
  logic       victim_valid_o;
  logic [2:0] victim_idx_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tlb_victim_sel #(.N_ENTRIES(8)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cache_off_i    (cache_off_i),
    .valid_i        (valid_i),
    .alloc_req_i    (alloc_req_i),
    .touch_req_i    (touch_req_i),
    .touch_idx_i    (touch_idx_i),
    .repl_mode_i    (repl_mode_i),
    .tie_sel_i      (tie_sel_i),
    .victim_valid_o (victim_valid_o),
    .victim_idx_o   (victim_idx_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       a;
    logic       t;
    logic [2:0] ti;
    logic       m;
    logic       s;
    logic [7:0] v;
    logic       off;
    logic       ev;
    logic [2:0] ei;
    logic [3:0] req;
  } vec_t;

  // Hand-derived from the requirements, starting from reset.
  // Ages are listed slot 0..7 after each row.
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    // R2: slot1 empty, RR mode -> 1   ages 1,0,1,1,1,1,1,1 ptr1
    '{1'b1,1'b0,3'd0,1'b0,1'b0,8'hFD,1'b0,1'b1,3'd1,4'd2},
    // R2: slot2 empty, LRU mode -> 2  ages 2,1,0,2,2,2,2,2 ptr2
    '{1'b1,1'b0,3'd0,1'b1,1'b0,8'hFB,1'b0,1'b1,3'd2,4'd2},
    // R5: oldest {0,3..7}, scan from 2 -> 3   ages 3,2,1,0,3,3,3,3 ptr3
    '{1'b1,1'b0,3'd0,1'b1,1'b1,8'hFF,1'b0,1'b1,3'd3,4'd5},
    // R4: oldest {0,4..7}, from 0 -> 0   ages 0,3,2,1,4,4,4,4 ptr4
    '{1'b1,1'b0,3'd0,1'b1,1'b0,8'hFF,1'b0,1'b1,3'd0,4'd4},
    // R3: RR -> ptr 4   ages 1,4,3,2,0,5,5,5 ptr5
    '{1'b1,1'b0,3'd0,1'b0,1'b0,8'hFF,1'b0,1'b1,3'd4,4'd3},
    // R6: touch 6, no victim   ages 2,5,4,3,1,6,0,6
    '{1'b0,1'b1,3'd6,1'b0,1'b0,8'hFF,1'b0,1'b0,3'd0,4'd6},
    // R6: oldest {5,7} -> 5   ages 3,6,5,4,2,0,1,7 ptr6
    '{1'b1,1'b0,3'd0,1'b1,1'b1,8'hFF,1'b0,1'b1,3'd5,4'd6},
    // R6: unique oldest 7   ages 4,7,6,5,3,1,2,0 ptr7
    '{1'b1,1'b0,3'd0,1'b1,1'b0,8'hFF,1'b0,1'b1,3'd7,4'd6},
    // R7: alloc RR -> 7 with touch of 1 ignored   ptr0
    '{1'b1,1'b1,3'd1,1'b0,1'b0,8'hFF,1'b0,1'b1,3'd7,4'd7},
    // R7: slot 1 still oldest -> 1   ages 5,0,7,6,4,2,3,1 ptr1
    '{1'b1,1'b0,3'd0,1'b1,1'b0,8'hFF,1'b0,1'b1,3'd1,4'd7}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one request for one cycle, then sample at the next falling edge.
  task automatic step(input logic a, input logic t, input logic [2:0] ti,
                      input logic m, input logic s, input logic [7:0] v,
                      input logic off);
    @(negedge clk);
    alloc_req_i = a;
    touch_req_i = t;
    touch_idx_i = ti;
    repl_mode_i = m;
    tie_sel_i   = s;
    valid_i     = v;
    cache_off_i = off;
    @(negedge clk);
    alloc_req_i = 1'b0;
    touch_req_i = 1'b0;
    cache_off_i = 1'b0;
  endtask

  task automatic expect_victim(input logic ev, input logic [2:0] ei, input string req);
    check(victim_valid_o == ev, req, int'(victim_valid_o), int'(ev));
    if (ev) check(victim_idx_o == ei, req, int'(victim_idx_o), int'(ei));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    cache_off_i = 1'b0;
    valid_i     = 8'h00;
    alloc_req_i = 1'b0;
    touch_req_i = 1'b0;
    touch_idx_i = 3'd0;
    repl_mode_i = 1'b0;
    tie_sel_i   = 1'b0;
    do_reset();
    @(negedge clk);
    check(victim_valid_o == 1'b0, "R1", int'(victim_valid_o), 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].a, VEC[i].t, VEC[i].ti, VEC[i].m, VEC[i].s, VEC[i].v, VEC[i].off);
      expect_victim(VEC[i].ev, VEC[i].ei, $sformatf("R%0d row%0d", VEC[i].req, i));
    end

    // R9: pulse lasts one cycle
    @(negedge clk);
    check(victim_valid_o == 1'b0, "R9", int'(victim_valid_o), 0);

    // R8: cache off blocks an allocation and a touch of slot 2 (age 7)
    step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFF, 1'b1);
    expect_victim(1'b0, 3'd0, "R8 alloc while off");
    step(1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 8'hFF, 1'b1);
    // R8: pointer unmoved -> RR picks 1
    step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFF, 1'b0);
    expect_victim(1'b1, 3'd1, "R8 pointer held");
    // R8/R10: slot 2 kept age 7 across mode switch -> LRU picks 2
    step(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 8'hFF, 1'b0);
    expect_victim(1'b1, 3'd2, "R10 ages kept");

    // R1: reset from non-uniform ages; all tie at 0 -> slot 0
    do_reset();
    @(negedge clk);
    check(victim_valid_o == 1'b0, "R1", int'(victim_valid_o), 0);
    step(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 8'hFF, 1'b0);
    expect_victim(1'b1, 3'd0, "R1 ages and pointer cleared");

    // R5: wrap. Fill 2 then 3, touch 4..7 -> oldest {0,1}, pointer 2 -> 0
    do_reset();
    step(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 8'hFB, 1'b0);
    expect_victim(1'b1, 3'd2, "R2 empty slot");
    step(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 8'hF7, 1'b0);
    expect_victim(1'b1, 3'd3, "R2 empty slot");
    for (int k = 4; k < 8; k++) begin
      step(1'b0, 1'b1, 3'(k), 1'b1, 1'b1, 8'hFF, 1'b0);
    end
    step(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 8'hFF, 1'b0);
    expect_victim(1'b1, 3'd0, "R5 wrap");
    // R9: index holds after pulse
    @(negedge clk);
    check(victim_idx_o == 3'd0, "R9 hold", int'(victim_idx_o), 0);

    finish_run();
  end

endmodule